// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A one-byte holding stage sits in front of the frame serializer, so software-side logic can hand over the next byte while the current one is still going out. Bit timing comes from an external one-cycle baud tick. The block does not divide clocks itself.

Control arrives as single-cycle command pulses: enable, disable and reset. A disable lets any byte that is shifting or waiting finish before the block switches off. A reset throws everything away at once. A mode input picks the parity bit. Two status outputs show whether the holding stage can take a byte and whether the block has gone fully quiet.

Top module: `uatx_top`

## Requirements
- R1: After `rst_n` is released, and after a reset command, the block is disabled: `hold_ready` is 0, `all_empty` is 1 and `txd` is 1.
- R2: A write strobe is ignored while the block is disabled or draining, and also while the holding stage is full. An ignored write sends no frame and leaves `all_empty` unchanged.
- R3: A frame is one start bit at 0, then the 8 data bits with bit 0 first, then the parity bit if the mode enables one, then one stop bit at 1.
- R4: `par_sel` encoding: 0 means no parity bit, 1 means odd (the data bits plus parity hold an odd number of ones), 2 means even, 3 means a constant 0 bit, 4 means a constant 1 bit, and 5 to 7 mean no parity bit. The mode is captured when the byte moves into the serializer.
- R5: `txd` is 1 whenever no frame is being sent, including while the block is disabled.
- R6: `hold_ready` is 1 exactly when the block is enabled, is not draining, and the holding stage is empty. An accepted write drops it on the next cycle.
- R7: Each bit occupies one full baud tick period. A byte written while the serializer is idle moves across on the next cycle, and its start bit begins on the first tick after that. A byte that is waiting when a stop bit ends is taken at that same tick and its start bit begins at once, so frames follow each other with no gap.
- R8: `all_empty` is 1 only when the holding stage is empty and no frame is in progress. It stays 0 through the whole stop bit and rises on the tick that ends it.
- R9: A disable command given while nothing is held or shifting turns the block off on the next cycle. Otherwise the shifting byte and the waiting byte are both sent in full, and the block then turns itself off.
- R10: A reset command aborts any frame at once and clears the holding stage. If commands arrive in the same cycle, reset wins over disable, and disable wins over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Enable command pulse |
| cmd_dis | input | 1 | Graceful disable command pulse |
| cmd_rst | input | 1 | Abort-and-clear command pulse |
| par_sel | input | 3 | Parity mode (encoding in R4) |
| wr_stb | input | 1 | Write strobe for the holding stage |
| wr_data | input | DATA_W | Byte to send |
| baud_tick | input | 1 | One-cycle pulse per serial bit period |
| txd | output | 1 | Serial output line |
| hold_ready | output | 1 | Holding stage can accept a byte |
| all_empty | output | 1 | Nothing held and no frame in progress |

## Verification
The assertions watch several properties on every cycle:
- the line is high when the serializer is idle or armed;
- a start bit is low and a stop bit is high;
- the line changes only on a tick or a reset;
- a reset command leaves the block quiet on the next cycle;
- an accepted write drops ready;
- a disabled block never fills its holding stage;
- a finished drain turns the block off.

Other behaviour can only be shown by the bench's scenarios:
- whole-frame contents, including data order and parity under every mode;
- back-to-back frames with no gap between them;
- draining of two pending bytes after a disable;
- the abort of a half-sent frame.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_ARMED,
        SH_START,
        SH_DATA,
        SH_PARITY,
        SH_STOP
    } sh_state_e;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_SPACE = 3'd3;
    localparam logic [2:0] PAR_MARK  = 3'd4;

endpackage

// File: rtl/uatx_parity.sv
module uatx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        mode,
    output logic              par_en,
    output logic              par_bit
);
    import uatx_pkg::*;

    always_comb begin
        par_en  = 1'b1;
        par_bit = 1'b0;
        case (mode)
            PAR_ODD:   par_bit = ~(^data);
            PAR_EVEN:  par_bit = ^data;
            PAR_SPACE: par_bit = 1'b0;
            PAR_MARK:  par_bit = 1'b1;
            default:   par_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/uatx_shift.sv
module uatx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [2:0]        ld_mode,
    output logic              ld_take,
    output logic              txd,
    output logic              idle
);
    import uatx_pkg::*;

    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        sh_state_e         st;
        logic [DATA_W-1:0] sr;
        logic [IDX_W-1:0]  idx;
        logic              pen;
        logic              pbit;
        logic              txd;
    } sh_t;

    sh_t sh_d, sh_q;
    logic new_pen, new_pbit;

    uatx_parity #(.DATA_W(DATA_W)) u_par (
        .data    (ld_data),
        .mode    (ld_mode),
        .par_en  (new_pen),
        .par_bit (new_pbit)
    );

    always_comb begin
        sh_d    = sh_q;
        ld_take = 1'b0;
        if (flush) begin
            sh_d.st  = SH_IDLE;
            sh_d.txd = 1'b1;
        end else begin
            case (sh_q.st)
                SH_IDLE: begin
                    if (ld_valid) begin
                        ld_take   = 1'b1;
                        sh_d.sr   = ld_data;
                        sh_d.pen  = new_pen;
                        sh_d.pbit = new_pbit;
                        sh_d.st   = SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (tick) begin
                        sh_d.txd = 1'b0;
                        sh_d.st  = SH_START;
                    end
                end
                SH_START: begin
                    if (tick) begin
                        sh_d.txd = sh_q.sr[0];
                        sh_d.sr  = sh_q.sr >> 1;
                        sh_d.idx = '0;
                        sh_d.st  = SH_DATA;
                    end
                end
                SH_DATA: begin
                    if (tick) begin
                        if (sh_q.idx == LAST_IDX) begin
                            if (sh_q.pen) begin
                                sh_d.txd = sh_q.pbit;
                                sh_d.st  = SH_PARITY;
                            end else begin
                                sh_d.txd = 1'b1;
                                sh_d.st  = SH_STOP;
                            end
                        end else begin
                            sh_d.txd = sh_q.sr[0];
                            sh_d.sr  = sh_q.sr >> 1;
                            sh_d.idx = sh_q.idx + 1'b1;
                        end
                    end
                end
                SH_PARITY: begin
                    if (tick) begin
                        sh_d.txd = 1'b1;
                        sh_d.st  = SH_STOP;
                    end
                end
                SH_STOP: begin
                    if (tick) begin
                        if (ld_valid) begin
                            ld_take   = 1'b1;
                            sh_d.sr   = ld_data;
                            sh_d.pen  = new_pen;
                            sh_d.pbit = new_pbit;
                            sh_d.txd  = 1'b0;
                            sh_d.st   = SH_START;
                        end else begin
                            sh_d.txd = 1'b1;
                            sh_d.st  = SH_IDLE;
                        end
                    end
                end
                default: begin
                    sh_d.st  = SH_IDLE;
                    sh_d.txd = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.st   <= SH_IDLE;
            sh_q.txd  <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd  = sh_q.txd;
    assign idle = (sh_q.st == SH_IDLE);

    // R5: line stays high before a frame's start bit
    a_r5_line_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.st == SH_IDLE || sh_q.st == SH_ARMED) |-> sh_q.txd);

    // R3: start bit low, stop bit high
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.st == SH_START) |-> !sh_q.txd);
    a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.st == SH_STOP) |-> sh_q.txd);

    // R7: the line only moves on a baud tick or a flush
    a_r7_bit_held_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flush) |=> $stable(sh_q.txd));

endmodule

// File: rtl/uatx_hold.sv
module uatx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sh_take,
    input  logic              sh_idle,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_ready,
    output logic              flush
);
    typedef struct packed {
        logic              en;
        logic              drain;
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hd_d, hd_q;
    logic  accept;

    always_comb begin
        hd_d   = hd_q;
        accept = wr_stb && hd_q.en && !hd_q.drain && !hd_q.full;
        if (cmd_rst) begin
            hd_d = '0;
        end else begin
            if (sh_take) begin
                hd_d.full = 1'b0;
            end
            if (accept) begin
                hd_d.full = 1'b1;
                hd_d.data = wr_data;
            end
            if (cmd_dis) begin
                if (hd_q.en) begin
                    if (sh_idle && !hd_q.full && !accept) begin
                        hd_d.en    = 1'b0;
                        hd_d.drain = 1'b0;
                    end else begin
                        hd_d.drain = 1'b1;
                    end
                end
            end else if (cmd_en) begin
                hd_d.en    = 1'b1;
                hd_d.drain = 1'b0;
            end else if (hd_q.drain && sh_idle && !hd_q.full) begin
                hd_d.en    = 1'b0;
                hd_d.drain = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign hold_valid = hd_q.full;
    assign hold_data  = hd_q.data;
    assign hold_ready = hd_q.en && !hd_q.drain && !hd_q.full;
    assign flush      = cmd_rst;

    // R2: a disabled block never fills its holding stage
    a_r2_no_fill_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!hd_q.en) |=> !hd_q.full);

    // R9: a finished drain turns the block off
    a_r9_drain_ends_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_q.drain && sh_idle && !hd_q.full && !cmd_en && !cmd_rst) |=> !hd_q.en);

endmodule

// File: rtl/uatx_top.sv
module uatx_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_rst,
    input  logic [2:0]        par_sel,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              txd,
    output logic              hold_ready,
    output logic              all_empty
);
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              sh_take;
    logic              sh_idle;
    logic              flush;

    uatx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_en     (cmd_en),
        .cmd_dis    (cmd_dis),
        .cmd_rst    (cmd_rst),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .sh_take    (sh_take),
        .sh_idle    (sh_idle),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .hold_ready (hold_ready),
        .flush      (flush)
    );

    uatx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .tick     (baud_tick),
        .ld_valid (hold_valid),
        .ld_data  (hold_data),
        .ld_mode  (par_sel),
        .ld_take  (sh_take),
        .txd      (txd),
        .idle     (sh_idle)
    );

    assign all_empty = sh_idle && !hold_valid;

    // R10: a reset command leaves the block quiet on the next cycle
    a_r10_reset_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (txd && !hold_ready && all_empty));

    // R6: an accepted write drops ready on the next cycle
    a_r6_write_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ready && wr_stb && !cmd_rst) |=> !hold_ready);

endmodule

// File: tb/sim_uatx_top.sv
`timescale 1ns/1ps
module sim_uatx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_en = 1'b0, cmd_dis = 1'b0, cmd_rst = 1'b0;
    logic [2:0] par_sel = 3'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       baud_tick = 1'b0;
    logic       txd, hold_ready, all_empty;

    always #2 clk = ~clk;

    uatx_top #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
        .cmd_rst(cmd_rst), .par_sel(par_sel), .wr_stb(wr_stb),
        .wr_data(wr_data), .baud_tick(baud_tick), .txd(txd),
        .hold_ready(hold_ready), .all_empty(all_empty)
    );

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_q[$];
    int dpos = -1;
    logic [10:0] cur;
    logic [7:0] got;
    int tick_cnt = 0;
    int start_ticks[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] par_of(input logic [7:0] d, input logic [2:0] m);
        case (m)
            3'd1:    return {1'b1, ~(^d)};
            3'd2:    return {1'b1, ^d};
            3'd3:    return 2'b10;
            3'd4:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic decode(input logic b);
        logic [1:0] pe;
        tick_cnt++;
        if (dpos < 0) begin
            if (!b) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected start bit", 0, 1);
                end else begin
                    cur = exp_q.pop_front();
                    dpos = 0;
                    got = 8'd0;
                    start_ticks.push_back(tick_cnt);
                end
            end
        end else begin
            dpos++;
            pe = par_of(cur[7:0], cur[10:8]);
            if (dpos <= 8) begin
                got[dpos-1] = b;
                if (dpos == 8) chk(got == cur[7:0], "R3", "data byte", got, cur[7:0]);
            end else if (dpos == 9 && pe[1]) begin
                chk(b == pe[0], "R4", "parity bit", b, pe[0]);
            end else begin
                chk(b == 1'b1, "R3", "stop bit", b, 1);
                chk(all_empty == 1'b0, "R8", "empty during stop bit", all_empty, 0);
                dpos = -1;
            end
        end
    endtask

    initial begin
        forever begin
            repeat (7) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            if (rst_n) decode(txd);
        end
    end

    task automatic pulse(input bit e, input bit d, input bit r);
        @(negedge clk);
        cmd_en = e; cmd_dis = d; cmd_rst = r;
        @(negedge clk);
        cmd_en = 1'b0; cmd_dis = 1'b0; cmd_rst = 1'b0;
    endtask

    task automatic write_ready(input logic [7:0] d);
        while (!hold_ready) @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        exp_q.push_back({par_sel, d});
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic write_ignored(input logic [7:0] d, input string req);
        chk(hold_ready == 1'b0, req, "ready low before ignored write", hold_ready, 0);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        chk(all_empty == 1'b1, req, "empty after ignored write", all_empty, 1);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 8) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || dpos >= 0 || !all_empty) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int n0;
        void'($urandom(32'h5EED1));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(hold_ready == 1'b0, "R1", "ready after reset", hold_ready, 0);
        chk(all_empty == 1'b1, "R1", "empty after reset", all_empty, 1);

        // R2 write while disabled
        write_ignored(8'h5A, "R2");
        wait_ticks(15);
        chk(start_ticks.size() == 0, "R2", "frames after disabled write", start_ticks.size(), 0);
        chk(txd == 1'b1, "R5", "line idle while disabled", txd, 1);

        // enable
        pulse(1, 0, 0);
        chk(hold_ready == 1'b1, "R6", "ready after enable", hold_ready, 1);

        // single frame, even parity, R7 transfer timing
        par_sel = 3'd2;
        write_ready(8'hA5);
        chk(hold_ready == 1'b0, "R6", "ready low while held", hold_ready, 0);
        chk(all_empty == 1'b0, "R8", "empty low after write", all_empty, 0);
        @(negedge clk);
        chk(hold_ready == 1'b1, "R7", "ready back after transfer", hold_ready, 1);
        wait_idle();
        chk(all_empty == 1'b1, "R8", "empty after frame", all_empty, 1);
        chk(txd == 1'b1, "R5", "line idle after frame", txd, 1);

        // back-to-back, odd parity
        par_sel = 3'd1;
        n0 = start_ticks.size();
        write_ready(8'h3C);
        write_ready(8'h81);
        chk(hold_ready == 1'b0, "R6", "ready low with byte waiting", hold_ready, 0);
        wait_idle();
        chk(start_ticks.size() == n0 + 2, "R7", "two frames sent", start_ticks.size(), n0 + 2);
        if (start_ticks.size() == n0 + 2)
            chk(start_ticks[n0+1] - start_ticks[n0] == 11, "R7", "no gap between frames",
                start_ticks[n0+1] - start_ticks[n0], 11);
        chk(hold_ready == 1'b1, "R6", "ready after drain of queue", hold_ready, 1);

        // each remaining mode, R4
        par_sel = 3'd3; write_ready(8'hFF); wait_idle();
        par_sel = 3'd4; write_ready(8'h00); wait_idle();
        par_sel = 3'd0; write_ready(8'h12); wait_idle();
        par_sel = 3'd7; write_ready(8'h34); wait_idle();

        // random batches
        for (int i = 0; i < 40; i++) begin
            int nb;
            par_sel = 3'($urandom % 8);
            nb = 1 + int'($urandom % 3);
            for (int j = 0; j < nb; j++) begin
                write_ready(8'($urandom));
                repeat ($urandom % 20) @(negedge clk);
            end
            wait_idle();
        end

        // R9 disable when idle
        pulse(0, 1, 0);
        chk(hold_ready == 1'b0, "R9", "ready after idle disable", hold_ready, 0);
        n0 = start_ticks.size();
        write_ignored(8'h77, "R2");
        wait_ticks(15);
        chk(start_ticks.size() == n0, "R9", "no frame after idle disable", start_ticks.size(), n0);

        // R9 disable with pending bytes drains both
        pulse(1, 0, 0);
        par_sel = 3'd2;
        n0 = start_ticks.size();
        write_ready(8'hC6);
        write_ready(8'h19);
        pulse(0, 1, 0);
        write_ignored_busy: begin
            chk(hold_ready == 1'b0, "R9", "ready low while draining", hold_ready, 0);
            wr_stb = 1'b1; wr_data = 8'hEE;
            @(negedge clk);
            wr_stb = 1'b0;
        end
        wait_idle();
        chk(start_ticks.size() == n0 + 2, "R9", "drained frames", start_ticks.size(), n0 + 2);
        chk(hold_ready == 1'b0, "R9", "off after drain", hold_ready, 0);
        n0 = start_ticks.size();
        write_ignored(8'h66, "R2");
        wait_ticks(15);
        chk(start_ticks.size() == n0, "R2", "no frame after drain", start_ticks.size(), n0);

        // R10 reset mid-frame
        pulse(1, 0, 0);
        par_sel = 3'd0;
        write_ready(8'hC3);
        while (dpos != 4) @(negedge clk);
        pulse(0, 0, 1);
        dpos = -1;
        exp_q.delete();
        chk(txd == 1'b1, "R10", "txd after abort", txd, 1);
        chk(hold_ready == 1'b0, "R10", "ready after abort", hold_ready, 0);
        chk(all_empty == 1'b1, "R10", "empty after abort", all_empty, 1);
        n0 = start_ticks.size();
        wait_ticks(15);
        chk(start_ticks.size() == n0, "R10", "no frame after abort", start_ticks.size(), n0);

        // R10 priority
        pulse(1, 0, 1);
        chk(hold_ready == 1'b0, "R10", "reset beats enable", hold_ready, 0);
        pulse(1, 1, 0);
        chk(hold_ready == 1'b0, "R10", "disable beats enable", hold_ready, 0);
        pulse(1, 0, 0);
        chk(hold_ready == 1'b1, "R10", "enable alone after priority", hold_ready, 1);

        summary();
        $finish;
    end

endmodule